// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a simple host register port and a bank of internal control registers that are not mapped onto the host bus. The host sees seven 32-bit words at 16-byte spacing: a status word, a read-only revision word, an address word and four staging data words. Writing the address word starts a transaction to the internal register that the address names. The transaction either commits the staged data or fetches one 16-bit slice of the target into data word 0.

Internal registers can be wider than the 16-bit data words. Software loads up to four staging words and then writes the address. Every slice of the target is then updated in the same cycle. A wide register is read back one slice per transaction, and a 2-bit index in the address word picks the slice. A sequencer holds a busy flag for a fixed number of cycles per transaction. While busy is set, further address writes are dropped.

Top module: `ind_reg_bridge`

## Requirements
- R1: Host offsets are 0x10 status, 0x20 revision, 0x30 address, and 0x40, 0x50, 0x60, 0x70 for staging words 0 to 3. Reads of any other offset return zero, and writes to them change nothing. Address and staging words hold bits 15:0 and read with bits 31:16 at zero.
- R2: The revision word is read-only and has zero above bit 15. Bit 15 is the inverse of the AUDIO_PRESENT parameter. Bits 14:12 are BOARD_REV, bits 7:4 are CHIP_MAJOR and bits 3:0 are CHIP_MINOR.
- R3: Status bit 3 drives `glb_rst_n_o` and bit 4 drives `cdc_rst_n_o`. Both are writable and reset to 0. Status bit 0 reads 1 while a transaction runs and ignores host writes.
- R4: Only a host write to offset 0x30 starts a transaction, and only when none is running. Busy then reads 1 for exactly BUSY_CYCLES cycles after that write edge.
- R5: A write to offset 0x30 while busy leaves the address word unchanged and starts nothing.
- R6: The address word has these fields: bits 15:12 block type (1 DMA port, 2 clock generator, 3 timer, 9 global control), bits 11:8 instance, bit 7 direction (1 read, 0 write), bits 3:2 parameter and bits 1:0 read slice index.
- R7: A write transaction commits the staged words when busy clears. A 16-bit target takes word 0. A 32-bit target takes word 0 as bits 15:0 and word 1 as bits 31:16. A 64-bit target takes words 0 to 3 from low to high.
- R8: A read transaction puts slice `index` of the target (bits index*16+15 down to index*16) into staging word 0 by the time busy clears. A slice above the target's width reads zero.
- R9: An address that names no internal register completes normally. Its write is discarded, and its read loads zero into staging word 0.
- R10: The internal targets are as follows. 0x1404 is a 16-bit DMA control. 0x1408 is a 32-bit DMA control. 0x3104 is a 64-bit timer value. 0x9104 is a 5-bit port-enable field with the bits above it reading 0. 0x2n04 for n = 1 to NUM_CLKGEN are 2-bit clock source selectors, each independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 8 | Host byte offset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from hst_addr |
| glb_rst_n_o | output | 1 | Global reset line from status bit 3 |
| cdc_rst_n_o | output | 1 | Codec reset line from status bit 4 |

## Verification
The bench builds the bridge with the default BUSY_CYCLES of 4 and three clock generators. It overrides all four revision parameters, including AUDIO_PRESENT = 0, so that every revision field and the inverted presence bit carry non-default values. Four busy cycles leave room to issue a second address write in the middle of a transaction. The three generator instances let the bench show that one write touches only the instance it names.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;
    localparam int NUM_IDR = 4;
    localparam int WORD_W  = 16;

    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_REV    = 8'h20;
    localparam logic [7:0] OFS_IAR    = 8'h30;
    localparam logic [7:0] OFS_IDR0   = 8'h40;
    localparam logic [7:0] OFS_STRIDE = 8'h10;

    typedef enum logic [3:0] {
        BLK_DMA    = 4'h1,
        BLK_CLKGEN = 4'h2,
        BLK_TIMER  = 4'h3,
        BLK_GLOBAL = 4'h9
    } blk_e;

    typedef enum logic [2:0] {
        RS_NONE, RS_STATUS, RS_REV, RS_IAR, RS_IDR
    } rsel_e;

    // layout of the indirect address word (R6)
    typedef struct packed {
        logic [3:0] blk;
        logic [3:0] inst;
        logic       rd;
        logic [2:0] rsvd;
        logic [1:0] param;
        logic [1:0] idx;
    } iaddr_t;
endpackage

// File: rtl/ibr_host_decode.sv
`timescale 1ns/1ps
module ibr_host_decode
    import ibr_pkg::*;
(
    input  logic [7:0]         hst_addr,
    input  logic               hst_wr,
    output logic               wr_status,
    output logic               wr_iar,
    output logic [NUM_IDR-1:0] wr_idr,
    output rsel_e              rsel,
    output logic [1:0]         idr_idx
);
    logic [NUM_IDR-1:0] hit_idr;

    for (genvar g = 0; g < NUM_IDR; g++) begin : g_idr
        localparam logic [7:0] OFS = OFS_IDR0 + 8'(g) * OFS_STRIDE;
        assign hit_idr[g] = (hst_addr == OFS);
        assign wr_idr[g]  = hst_wr && hit_idr[g];
    end

    assign wr_status = hst_wr && (hst_addr == OFS_STATUS);
    assign wr_iar    = hst_wr && (hst_addr == OFS_IAR);

    always_comb begin
        rsel    = RS_NONE;
        idr_idx = '0;
        if (hst_addr == OFS_STATUS)   rsel = RS_STATUS;
        else if (hst_addr == OFS_REV) rsel = RS_REV;
        else if (hst_addr == OFS_IAR) rsel = RS_IAR;
        for (int i = 0; i < NUM_IDR; i++) begin
            if (hit_idr[i]) begin
                rsel    = RS_IDR;
                idr_idx = 2'(i);
            end
        end
    end
endmodule

// File: rtl/ibr_txn_seq.sv
`timescale 1ns/1ps
module ibr_txn_seq
    import ibr_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch,
    input  iaddr_t addr_in,
    output logic   busy,
    output logic   done,
    output iaddr_t cur_addr
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        iaddr_t        addr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        done = q.busy && (q.cnt == '0);
        if (done) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
        end
        if (launch && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CW'(BUSY_CYCLES - 1);
            d.addr = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign cur_addr = q.addr;
endmodule

// File: rtl/ibr_target_bank.sv
`timescale 1ns/1ps
module ibr_target_bank
    import ibr_pkg::*;
#(
    parameter int NUM_CLKGEN = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            done,
    input  iaddr_t                          addr,
    input  logic [NUM_IDR-1:0][WORD_W-1:0]  stage,
    output logic [WORD_W-1:0]               rd_word
);
    localparam int STG_W  = NUM_IDR * WORD_W;
    localparam int PE_W   = 5;
    localparam int CSEL_W = 2;

    typedef struct packed {
        logic [15:0]                        dma_c1;
        logic [31:0]                        dma_c2;
        logic [63:0]                        tmr;
        logic [PE_W-1:0]                    port_en;
        logic [NUM_CLKGEN-1:0][CSEL_W-1:0]  csel;
    } bank_t;

    bank_t q, d;

    logic                  hit_c1, hit_c2, hit_tmr, hit_pe;
    logic [NUM_CLKGEN-1:0] hit_cg;
    logic [STG_W-1:0]      view;
    logic [STG_W-1:0]      stg_flat;
    logic                  unused_rsvd;

    assign unused_rsvd = ^addr.rsvd;
    assign stg_flat    = stage;

    assign hit_c1  = (addr.blk == BLK_DMA)    && (addr.inst == 4'd4) && (addr.param == 2'd1);
    assign hit_c2  = (addr.blk == BLK_DMA)    && (addr.inst == 4'd4) && (addr.param == 2'd2);
    assign hit_tmr = (addr.blk == BLK_TIMER)  && (addr.inst == 4'd1) && (addr.param == 2'd1);
    assign hit_pe  = (addr.blk == BLK_GLOBAL) && (addr.inst == 4'd1) && (addr.param == 2'd1);

    for (genvar g = 0; g < NUM_CLKGEN; g++) begin : g_cg
        assign hit_cg[g] = (addr.blk == BLK_CLKGEN) && (addr.inst == 4'(g + 1))
                           && (addr.param == 2'd1);
    end

    // zero-extended view of the addressed target; nothing hit gives zero
    always_comb begin
        view = '0;
        if (hit_c1)  view = STG_W'(q.dma_c1);
        if (hit_c2)  view = STG_W'(q.dma_c2);
        if (hit_tmr) view = STG_W'(q.tmr);
        if (hit_pe)  view = STG_W'(q.port_en);
        for (int i = 0; i < NUM_CLKGEN; i++) begin
            if (hit_cg[i]) view = STG_W'(q.csel[i]);
        end
    end

    assign rd_word = view[addr.idx * WORD_W +: WORD_W];

    always_comb begin
        d = q;
        if (done && !addr.rd) begin
            if (hit_c1)  d.dma_c1  = stg_flat[15:0];
            if (hit_c2)  d.dma_c2  = stg_flat[31:0];
            if (hit_tmr) d.tmr     = stg_flat[63:0];
            if (hit_pe)  d.port_en = stg_flat[PE_W-1:0];
            for (int i = 0; i < NUM_CLKGEN; i++) begin
                if (hit_cg[i]) d.csel[i] = stg_flat[CSEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int         BUSY_CYCLES   = 4,
    parameter int         NUM_CLKGEN    = 3,
    parameter logic       AUDIO_PRESENT = 1'b1,
    parameter logic [2:0] BOARD_REV     = 3'd5,
    parameter logic [3:0] CHIP_MAJOR    = 4'hA,
    parameter logic [3:0] CHIP_MINOR    = 4'h3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  hst_addr,
    input  logic        hst_wr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    output logic        glb_rst_n_o,
    output logic        cdc_rst_n_o
);
    localparam logic [31:0] REV_WORD = {16'h0, ~AUDIO_PRESENT, BOARD_REV, 4'h0,
                                        CHIP_MAJOR, CHIP_MINOR};

    typedef struct packed {
        logic                           glb_n;
        logic                           cdc_n;
        logic [WORD_W-1:0]              iar;
        logic [NUM_IDR-1:0][WORD_W-1:0] idr;
    } host_t;

    host_t q, d;

    logic               wr_status, wr_iar, launch;
    logic [NUM_IDR-1:0] wr_idr;
    rsel_e              rsel;
    logic [1:0]         idr_idx;
    logic               busy, txn_done;
    iaddr_t             cur_addr;
    logic [WORD_W-1:0]  rd_word;
    logic [WORD_W-1:0]  iar_val, idr0_val;
    logic               unused_hi;

    assign unused_hi = ^hst_wdata[31:16];

    ibr_host_decode u_dec (
        .hst_addr (hst_addr),
        .hst_wr   (hst_wr),
        .wr_status(wr_status),
        .wr_iar   (wr_iar),
        .wr_idr   (wr_idr),
        .rsel     (rsel),
        .idr_idx  (idr_idx)
    );

    assign launch = wr_iar && !busy;

    ibr_txn_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .addr_in (iaddr_t'(hst_wdata[15:0])),
        .busy    (busy),
        .done    (txn_done),
        .cur_addr(cur_addr)
    );

    ibr_target_bank #(.NUM_CLKGEN(NUM_CLKGEN)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (txn_done),
        .addr   (cur_addr),
        .stage  (q.idr),
        .rd_word(rd_word)
    );

    always_comb begin
        d = q;
        if (wr_status) begin
            d.glb_n = hst_wdata[3];
            d.cdc_n = hst_wdata[4];
        end
        if (launch) d.iar = hst_wdata[15:0];
        for (int i = 0; i < NUM_IDR; i++) begin
            if (wr_idr[i]) d.idr[i] = hst_wdata[15:0];
        end
        // a completing read wins over a host write to word 0 in the same cycle
        if (txn_done && cur_addr.rd) d.idr[0] = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rsel)
            RS_STATUS: hst_rdata = {27'h0, q.cdc_n, q.glb_n, 2'b00, busy};
            RS_REV:    hst_rdata = REV_WORD;
            RS_IAR:    hst_rdata = {16'h0, q.iar};
            RS_IDR:    hst_rdata = {16'h0, q.idr[idr_idx]};
            default:   hst_rdata = '0;
        endcase
    end

    assign iar_val     = q.iar;
    assign idr0_val    = q.idr[0];
    assign glb_rst_n_o = q.glb_n;
    assign cdc_rst_n_o = q.cdc_n;
endmodule

// File: rtl/ibr_checker.sv
`timescale 1ns/1ps
module ibr_checker
    import ibr_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  hst_addr,
    input logic        hst_wr,
    input logic        busy,
    input logic        done,
    input logic [15:0] iar,
    input logic [15:0] idr0
);
    localparam int RW = $clog2(BUSY_CYCLES + 2);

    logic [RW-1:0] run_len;
    logic          iar_wr, idr0_wr;

    assign iar_wr  = hst_wr && (hst_addr == OFS_IAR);
    assign idr0_wr = hst_wr && (hst_addr == OFS_IDR0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iar_wr && !busy) |=> busy);

    assert_no_spurious_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !iar_wr) |=> !busy);

    assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RW'(BUSY_CYCLES)));

    assert_iar_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iar_wr) |=> $stable(iar));

    assert_idr0_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !idr0_wr) |=> $stable(idr0));
endmodule

bind ind_reg_bridge ibr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hst_addr(hst_addr),
    .hst_wr  (hst_wr),
    .busy    (busy),
    .done    (txn_done),
    .iar     (iar_val),
    .idr0    (idr0_val)
);

// File: tb/tb_ind_reg_bridge.sv
`timescale 1ns/1ps
module tb_ind_reg_bridge;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  hst_addr;
    logic        hst_wr;
    logic [31:0] hst_wdata;
    logic [31:0] hst_rdata;
    logic        glb_rst_n_o, cdc_rst_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    ind_reg_bridge #(
        .BUSY_CYCLES  (BUSY),
        .NUM_CLKGEN   (3),
        .AUDIO_PRESENT(1'b0),
        .BOARD_REV    (3'd6),
        .CHIP_MAJOR   (4'h2),
        .CHIP_MINOR   (4'h7)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_addr   (hst_addr),
        .hst_wr     (hst_wr),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata),
        .glb_rst_n_o(glb_rst_n_o),
        .cdc_rst_n_o(cdc_rst_n_o)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        hst_addr  = a;
        hst_wdata = v;
        hst_wr    = 1'b1;
        @(negedge clk);
        hst_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        hst_addr = a;
        #1;
        v = hst_rdata;
    endtask

    task automatic txn(input logic [15:0] ia);
        wr(8'h30, {16'h0, ia});
        repeat (BUSY) tick();
    endtask

    task automatic rd_int(input logic [15:0] ia, output logic [31:0] v);
        txn(ia);
        rd(8'h40, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h10, v); chk("R3 status after reset", v, 32'h0);
        chk("R3 reset outputs", {30'h0, glb_rst_n_o, cdc_rst_n_o}, 32'h0);
        rd(8'h30, v); chk("R1 address word after reset", v, 32'h0);
        rd(8'h70, v); chk("R1 staging word 3 after reset", v, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        rd(8'h20, v); chk("R2 revision fields", v, 32'h0000_E027);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R2 revision read-only", v, 32'h0000_E027);
        rd(8'h00, v); chk("R1 unmapped offset 0x00", v, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R1 unmapped offset 0x14", v, 32'h0);
        rd(8'h10, v); chk("R1 stray write leaves status", v, 32'h0);
        wr(8'h60, 32'hFFFF_1234);
        rd(8'h60, v); chk("R1 staging word 2 holds low half", v, 32'h0000_1234);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(8'h10, 32'h0000_0018);
        rd(8'h10, v); chk("R3 reset bits written", v, 32'h18);
        chk("R3 reset outputs high", {30'h0, glb_rst_n_o, cdc_rst_n_o}, 32'h3);
        wr(8'h10, 32'h0000_0009);
        rd(8'h10, v); chk("R3 busy bit not writable", v, 32'h08);
        chk("R3 codec reset low", {30'h0, glb_rst_n_o, cdc_rst_n_o}, 32'h2);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(8'h40, 32'h0000_ABCD);
        rd(8'h10, v); chk("R4 staging write starts nothing", v & 32'h1, 32'h0);
        wr(8'h30, 32'h0000_1404);
        for (int i = 0; i < BUSY; i++) begin
            rd(8'h10, v); chk("R4 busy during transaction", v & 32'h1, 32'h1);
            tick();
        end
        rd(8'h10, v); chk("R4 busy clears after BUSY_CYCLES", v & 32'h1, 32'h0);
        rd_int(16'h1484, v); chk("R10 16-bit control read", v, 32'h0000_ABCD);
        rd_int(16'h1485, v); chk("R8 slice above width reads zero", v, 32'h0);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        wr(8'h40, 32'h1111);
        wr(8'h50, 32'h2222);
        txn(16'h1408);
        rd_int(16'h1488, v); chk("R7 32-bit slice 0", v, 32'h1111);
        rd_int(16'h1489, v); chk("R7 32-bit slice 1", v, 32'h2222);
        rd_int(16'h148A, v); chk("R8 32-bit slice 2 zero", v, 32'h0);
        wr(8'h40, 32'hA0A0);
        wr(8'h50, 32'hB1B1);
        wr(8'h60, 32'hC2C2);
        wr(8'h70, 32'hD3D3);
        txn(16'h3104);
        rd_int(16'h3187, v); chk("R7 64-bit slice 3", v, 32'hD3D3);
        rd_int(16'h3185, v); chk("R8 64-bit slice 1", v, 32'hB1B1);
        rd_int(16'h1489, v); chk("R7 32-bit target untouched by timer write", v, 32'h2222);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(8'h30, 32'h3184);
        tick();
        wr(8'h30, 32'h1488);
        rd(8'h30, v); chk("R5 address write ignored while busy", v, 32'h3184);
        tick(); tick();
        rd(8'h10, v); chk("R5 no second transaction", v & 32'h1, 32'h0);
        rd(8'h40, v); chk("R8 original read completed", v, 32'hA0A0);
        tick();
        rd(8'h10, v); chk("R5 busy stays clear", v & 32'h1, 32'h0);
    endtask

    task automatic t_targets();
        logic [31:0] v;
        wr(8'h40, 32'hFFFF);
        txn(16'h9104);
        rd_int(16'h9184, v); chk("R10 port enable width", v, 32'h1F);
        wr(8'h40, 32'h3);
        txn(16'h2204);
        rd_int(16'h2284, v); chk("R10 clock gen 2 written", v, 32'h3);
        rd_int(16'h2184, v); chk("R10 clock gen 1 untouched", v, 32'h0);
        wr(8'h40, 32'h6);
        txn(16'h2304);
        rd_int(16'h2384, v); chk("R6 clock gen 3 by instance field", v, 32'h2);
        rd_int(16'h2284, v); chk("R10 clock gen 2 kept", v, 32'h3);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h40, 32'hBEEF);
        txn(16'h5104);
        rd(8'h40, v); chk("R9 unmapped write keeps staging", v, 32'hBEEF);
        rd_int(16'h5184, v); chk("R9 unmapped read returns zero", v, 32'h0);
        rd_int(16'h3184, v); chk("R9 timer not hit by unmapped write", v, 32'hA0A0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        hst_wr    = 1'b0;
        hst_addr  = 8'h0;
        hst_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_map();
        t_status();
        t_busy();
        t_wide();
        t_ignore();
        t_targets();
        t_unmapped();
        finish_run();
    end
endmodule